// File: doc/BRIEF.md
# Strip-Mined Chained Vector Adder

This block forms the element-wise sum A[i] = B[i] + C[i] over N 32-bit words that sit in a plain memory. The memory is addressed by byte, with four bytes to a word. The work is cut into strips. Each strip covers at most 128 elements, because that is the depth of the two local operand buffers. A strip length register is loaded from the count of elements still to do and is clamped to the buffer depth. After each strip the remaining count drops by 128 and the three base pointers move on by 512 bytes. The last strip handles only the elements that are left over.

Inside a strip, B and C words are read through two independent read ports, one element per cycle on each. Every word that arrives is stored in its operand buffer and sets a valid flag for its slot. The adder does not wait for the strip load to finish. It takes element i as soon as both operand slots i are valid, which chains the add onto the loads that are still in flight. Sums leave through a single write port, one per cycle, in ascending element order.

The caller places the three base addresses and N on the inputs and pulses `start`. It then waits for the one-cycle `done` pulse.

Top module: `vec_strip_add`

## Requirements
- R1: After a synchronous reset, `done`, `b_rd_en`, `c_rd_en` and `a_wr_en` are all low.
- R2: Every element written to A equals B[i] + C[i] modulo 2^32. A carry out of bit 31 is discarded and no flag is raised.
- R3: A strip issues at most 128 reads on each read port. A run of N elements issues exactly N reads on each port in total.
- R4: Element i of a run lives at byte address base + 4*i for each of A, B and C. Between strips every base pointer advances by 512 bytes. Within a strip, consecutive reads step by 4 bytes.
- R5: When N is not a multiple of 128, the final strip touches only the leftover elements. Nothing is written at or above A base + 4*N.
- R6: Chaining. The add for element i starts only after both operands i have arrived, and it starts without waiting for the rest of the strip. With a read latency of one cycle, a run takes N + 3*S clock edges from the edge that samples `start` to the edge that raises `done`, where S is the number of strips (ceil(N/128)).
- R7: Writes to A are issued one per cycle in strictly ascending address order, with each address 4 bytes above the one before, across strip boundaries too.
- R8: With N = 0, `done` rises on the edge that samples `start`, and no read or write is issued.
- R9: `done` is high for exactly one cycle, in the cycle after the final write of the last strip.
- R10: While a run is in progress, `start` and the parameter inputs are ignored. The run finishes with its original N and bases, and nothing is written elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when the block is idle |
| n_elems | input | 32 | Number of elements N |
| a_base | input | 32 | Byte address of the result vector A |
| b_base | input | 32 | Byte address of operand vector B |
| c_base | input | 32 | Byte address of operand vector C |
| done | output | 1 | One-cycle completion pulse |
| b_rd_en | output | 1 | Read request on the B port |
| b_rd_addr | output | 32 | Byte address of the B read |
| b_rd_data | input | 32 | B read data, valid one cycle after the request |
| c_rd_en | output | 1 | Read request on the C port |
| c_rd_addr | output | 32 | Byte address of the C read |
| c_rd_data | input | 32 | C read data, valid one cycle after the request |
| a_wr_en | output | 1 | Write strobe for A |
| a_wr_addr | output | 32 | Byte address of the A write |
| a_wr_data | output | 32 | Sum being written |

## Verification
The embedded properties watch the following on every cycle:
- the strip length stays between 1 and 128;
- the operand loads never run ahead of that length;
- the adder never fires on an element that has not yet arrived on both ports;
- A writes step upward by 4 bytes without a break, even across strips;
- reads step by 4 bytes within a strip, and the bases move by 512 bytes between strips;
- the memory ports stay silent while idle;
- `done` never lasts two cycles.

Only the directed scenarios can show the rest:
- the arithmetic, including wraparound;
- the exact cycle count that proves chaining;
- that a partial final strip stops at N;
- that N = 0 finishes at once;
- that a `start` pulse in the middle of a run leaves both the run and a second memory region untouched.

// File: rtl/vsa_pkg.sv
`timescale 1ns/1ps
package vsa_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int CNT_W      = 32;
    localparam int ELEM_BYTES = DATA_W / 8;
    localparam int DEF_VLEN   = 128;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Current byte pointers of the three vectors for the active strip.
    typedef struct packed {
        addr_t a;
        addr_t b;
        addr_t c;
    } strip_ptr_t;

    // Byte offset of element idx within a strip.
    function automatic addr_t elem_offset(input int unsigned idx);
        return addr_t'(idx * ELEM_BYTES);
    endfunction

    // Element sum, modulo 2^DATA_W.
    function automatic data_t wrap_add(input data_t x, input data_t y);
        return x + y;
    endfunction

endpackage

// File: rtl/vsa_strip_ctrl.sv
`timescale 1ns/1ps
module vsa_strip_ctrl
    import vsa_pkg::*;
#(
    parameter int VLEN_MAX = DEF_VLEN,
    parameter int VL_W     = $clog2(VLEN_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  cnt_t            n_elems,
    input  strip_ptr_t      bases,
    input  logic            strip_fin,
    output logic            running,
    output logic            strip_go,
    output strip_ptr_t      ptr,
    output logic [VL_W-1:0] vl,
    output logic            done
);

    localparam cnt_t  VMAX_C      = cnt_t'(VLEN_MAX);
    localparam addr_t STRIP_BYTES = addr_t'(VLEN_MAX * ELEM_BYTES);

    run_state_e state;
    cnt_t       remaining;
    cnt_t       next_rem;
    logic       more_strips;
    logic       launch;

    function automatic logic [VL_W-1:0] clamp_vl(input cnt_t r);
        return (r > VMAX_C) ? VL_W'(VLEN_MAX) : r[VL_W-1:0];
    endfunction

    assign running     = (state == ST_RUN);
    assign more_strips = (remaining > VMAX_C);
    assign next_rem    = remaining - VMAX_C;
    assign launch      = (state == ST_IDLE) && start && (n_elems != '0);
    assign strip_go    = launch || (running && strip_fin && more_strips);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            remaining <= '0;
            ptr       <= '0;
            vl        <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (n_elems == '0) begin
                            done <= 1'b1;
                        end else begin
                            state     <= ST_RUN;
                            remaining <= n_elems;
                            ptr       <= bases;
                            vl        <= clamp_vl(n_elems);
                        end
                    end
                end
                ST_RUN: begin
                    if (strip_fin) begin
                        if (more_strips) begin
                            remaining <= next_rem;
                            ptr.a     <= ptr.a + STRIP_BYTES;
                            ptr.b     <= ptr.b + STRIP_BYTES;
                            ptr.c     <= ptr.c + STRIP_BYTES;
                            vl        <= clamp_vl(next_rem);
                        end else begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strip length is never zero and never exceeds the buffer depth.
    p_vl_range_r3: assert property (@(posedge clk) disable iff (rst)
        running |-> (vl != '0) && (vl <= VL_W'(VLEN_MAX)));

    // Pointers move by one strip worth of bytes between strips.
    p_base_step_r4: assert property (@(posedge clk) disable iff (rst)
        (running && strip_fin && more_strips) |=>
            (ptr.b == $past(ptr.b) + STRIP_BYTES) && (ptr.a == $past(ptr.a) + STRIP_BYTES));

    // Completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // start sampled while running leaves the remaining count alone unless a strip ends.
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (running && !strip_fin) |=> $stable(remaining) && $stable(ptr));

endmodule

// File: rtl/vsa_opnd_load.sv
`timescale 1ns/1ps
module vsa_opnd_load
    import vsa_pkg::*;
#(
    parameter int VLEN_MAX = DEF_VLEN,
    parameter int VL_W     = $clog2(VLEN_MAX + 1),
    parameter int SLOT_W   = $clog2(VLEN_MAX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            running,
    input  logic            strip_go,
    input  addr_t           base,
    input  logic [VL_W-1:0] vl,
    output logic            rd_en,
    output addr_t           rd_addr,
    input  data_t           rd_data,
    input  logic [VL_W-1:0] sel_idx,
    output data_t           elem,
    output logic            elem_vld,
    output logic [VL_W-1:0] arrived
);

    data_t               vbuf [VLEN_MAX];
    logic [VLEN_MAX-1:0] slot_vld;
    logic [VL_W-1:0]     ld_idx;
    logic                pend_v;
    logic [SLOT_W-1:0]   pend_slot;
    logic [SLOT_W-1:0]   sel_slot;
    logic                sel_ok;

    assign rd_en    = running && (ld_idx < vl);
    assign rd_addr  = base + elem_offset(int'(ld_idx));
    assign sel_ok   = (sel_idx < VL_W'(VLEN_MAX));
    assign sel_slot = sel_idx[SLOT_W-1:0];
    assign elem     = vbuf[sel_slot];
    assign elem_vld = sel_ok && slot_vld[sel_slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_idx    <= '0;
            pend_v    <= 1'b0;
            pend_slot <= '0;
            slot_vld  <= '0;
            arrived   <= '0;
        end else if (strip_go) begin
            ld_idx    <= '0;
            pend_v    <= 1'b0;
            slot_vld  <= '0;
            arrived   <= '0;
        end else begin
            pend_v    <= rd_en;
            pend_slot <= ld_idx[SLOT_W-1:0];
            if (rd_en) begin
                ld_idx <= ld_idx + 1'b1;
            end
            if (pend_v) begin
                slot_vld[pend_slot] <= 1'b1;
                arrived             <= arrived + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (pend_v) begin
            vbuf[pend_slot] <= rd_data;
        end
    end

    // Reads within a strip walk upward one element at a time.
    p_read_step_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + addr_t'(ELEM_BYTES)));

    // Loads never outrun the strip length.
    p_load_bound_r3: assert property (@(posedge clk) disable iff (rst)
        running |-> (arrived <= vl) && (ld_idx <= vl));

endmodule

// File: rtl/vsa_chain_add.sv
`timescale 1ns/1ps
module vsa_chain_add
    import vsa_pkg::*;
#(
    parameter int VLEN_MAX = DEF_VLEN,
    parameter int VL_W     = $clog2(VLEN_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            running,
    input  logic            strip_go,
    input  addr_t           a_base,
    input  logic [VL_W-1:0] vl,
    input  data_t           opnd_b,
    input  data_t           opnd_c,
    input  logic            vld_b,
    input  logic            vld_c,
    input  logic [VL_W-1:0] arr_b,
    input  logic [VL_W-1:0] arr_c,
    output logic [VL_W-1:0] sel_idx,
    output logic            wr_en,
    output addr_t           wr_addr,
    output data_t           wr_data,
    output logic            strip_fin
);

    logic [VL_W-1:0] add_idx;
    logic            fire;
    logic            last_elem;
    addr_t           prev_wr;
    logic            have_prev;

    assign sel_idx   = add_idx;
    assign fire      = running && (add_idx < vl) && vld_b && vld_c;
    assign last_elem = (add_idx == vl - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            add_idx   <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            strip_fin <= 1'b0;
        end else begin
            wr_en     <= fire;
            strip_fin <= fire && last_elem;
            if (strip_go) begin
                add_idx <= '0;
            end else if (fire) begin
                add_idx <= add_idx + 1'b1;
                wr_addr <= a_base + elem_offset(int'(add_idx));
                wr_data <= wrap_add(opnd_b, opnd_c);
            end
        end
    end

    // Checker state: address of the previous write of this run.
    always_ff @(posedge clk) begin
        if (rst || !running) begin
            prev_wr   <= '0;
            have_prev <= 1'b0;
        end else if (wr_en) begin
            prev_wr   <= wr_addr;
            have_prev <= 1'b1;
        end
    end

    // An add only consumes an element both loaders report as delivered.
    p_chain_ready_r6: assert property (@(posedge clk) disable iff (rst)
        fire |-> (arr_b > add_idx) && (arr_c > add_idx));

    // Writes form one unbroken ascending sequence across strips.
    p_wr_ascend_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && have_prev) |-> (wr_addr == prev_wr + addr_t'(ELEM_BYTES)));

    // The strip-end marker follows a write.
    p_fin_after_wr_r9: assert property (@(posedge clk) disable iff (rst)
        strip_fin |-> wr_en);

endmodule

// File: rtl/vec_strip_add.sv
`timescale 1ns/1ps
module vec_strip_add
    import vsa_pkg::*;
#(
    parameter int VLEN_MAX = DEF_VLEN
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] n_elems,
    input  logic [31:0] a_base,
    input  logic [31:0] b_base,
    input  logic [31:0] c_base,
    output logic        done,
    output logic        b_rd_en,
    output logic [31:0] b_rd_addr,
    input  logic [31:0] b_rd_data,
    output logic        c_rd_en,
    output logic [31:0] c_rd_addr,
    input  logic [31:0] c_rd_data,
    output logic        a_wr_en,
    output logic [31:0] a_wr_addr,
    output logic [31:0] a_wr_data
);

    localparam int VL_W    = $clog2(VLEN_MAX + 1);
    localparam int N_OPND  = 2;

    strip_ptr_t      bases_in;
    strip_ptr_t      ptr;
    logic            running;
    logic            strip_go;
    logic            strip_fin;
    logic [VL_W-1:0] vl;
    logic [VL_W-1:0] sel_idx;

    addr_t           op_base  [N_OPND];
    data_t           op_rdata [N_OPND];
    logic            op_rd_en [N_OPND];
    addr_t           op_raddr [N_OPND];
    data_t           op_elem  [N_OPND];
    logic            op_vld   [N_OPND];
    logic [VL_W-1:0] op_arr   [N_OPND];

    assign bases_in.a = a_base;
    assign bases_in.b = b_base;
    assign bases_in.c = c_base;

    vsa_strip_ctrl #(
        .VLEN_MAX (VLEN_MAX),
        .VL_W     (VL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .n_elems   (n_elems),
        .bases     (bases_in),
        .strip_fin (strip_fin),
        .running   (running),
        .strip_go  (strip_go),
        .ptr       (ptr),
        .vl        (vl),
        .done      (done)
    );

    assign op_base[0]  = ptr.b;
    assign op_base[1]  = ptr.c;
    assign op_rdata[0] = b_rd_data;
    assign op_rdata[1] = c_rd_data;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        vsa_opnd_load #(
            .VLEN_MAX (VLEN_MAX),
            .VL_W     (VL_W)
        ) u_load (
            .clk      (clk),
            .rst      (rst),
            .running  (running),
            .strip_go (strip_go),
            .base     (op_base[g]),
            .vl       (vl),
            .rd_en    (op_rd_en[g]),
            .rd_addr  (op_raddr[g]),
            .rd_data  (op_rdata[g]),
            .sel_idx  (sel_idx),
            .elem     (op_elem[g]),
            .elem_vld (op_vld[g]),
            .arrived  (op_arr[g])
        );
    end

    assign b_rd_en   = op_rd_en[0];
    assign b_rd_addr = op_raddr[0];
    assign c_rd_en   = op_rd_en[1];
    assign c_rd_addr = op_raddr[1];

    vsa_chain_add #(
        .VLEN_MAX (VLEN_MAX),
        .VL_W     (VL_W)
    ) u_add (
        .clk       (clk),
        .rst       (rst),
        .running   (running),
        .strip_go  (strip_go),
        .a_base    (ptr.a),
        .vl        (vl),
        .opnd_b    (op_elem[0]),
        .opnd_c    (op_elem[1]),
        .vld_b     (op_vld[0]),
        .vld_c     (op_vld[1]),
        .arr_b     (op_arr[0]),
        .arr_c     (op_arr[1]),
        .sel_idx   (sel_idx),
        .wr_en     (a_wr_en),
        .wr_addr   (a_wr_addr),
        .wr_data   (a_wr_data),
        .strip_fin (strip_fin)
    );

    // No memory traffic outside a run.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !running |-> !b_rd_en && !c_rd_en && !a_wr_en);

    // Both operand ports request in lockstep.
    p_ports_lockstep_r3: assert property (@(posedge clk) disable iff (rst)
        b_rd_en == c_rd_en);

endmodule

// File: tb/vec_strip_add_bench.sv
`timescale 1ns/1ps
module vec_strip_add_bench;

    localparam int    MEM_WORDS = 4096;
    localparam logic [31:0] B_BASE   = 32'h0000_1000;
    localparam logic [31:0] C_BASE   = 32'h0000_2000;
    localparam logic [31:0] A_BASE   = 32'h0000_3000;
    localparam logic [31:0] ALT_BASE = 32'h0000_3C00;
    localparam logic [31:0] GUARD    = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] n_elems = '0;
    logic [31:0] a_base = '0;
    logic [31:0] b_base = '0;
    logic [31:0] c_base = '0;
    logic        done;
    logic        b_rd_en, c_rd_en, a_wr_en;
    logic [31:0] b_rd_addr, c_rd_addr, a_wr_addr, a_wr_data;
    logic [31:0] b_rd_data, c_rd_data;

    logic [31:0] mem [MEM_WORDS];

    int checks = 0;
    int fails  = 0;
    int n_brd, n_crd, n_wr, n_done, n_order_err, n_hi_wr;
    logic [31:0] exp_wr;
    logic [31:0] wr_limit;

    always #4 clk = ~clk;

    vec_strip_add u_vec_strip_add (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .n_elems   (n_elems),
        .a_base    (a_base),
        .b_base    (b_base),
        .c_base    (c_base),
        .done      (done),
        .b_rd_en   (b_rd_en),
        .b_rd_addr (b_rd_addr),
        .b_rd_data (b_rd_data),
        .c_rd_en   (c_rd_en),
        .c_rd_addr (c_rd_addr),
        .c_rd_data (c_rd_data),
        .a_wr_en   (a_wr_en),
        .a_wr_addr (a_wr_addr),
        .a_wr_data (a_wr_data)
    );

    // Memory with one-cycle read latency.
    always @(posedge clk) begin
        if (b_rd_en) b_rd_data <= mem[b_rd_addr[13:2]];
        if (c_rd_en) c_rd_data <= mem[c_rd_addr[13:2]];
        if (a_wr_en) mem[a_wr_addr[13:2]] <= a_wr_data;
    end

    // Port monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst) begin
            if (b_rd_en) n_brd++;
            if (c_rd_en) n_crd++;
            if (done) n_done++;
            if (a_wr_en) begin
                n_wr++;
                if (a_wr_addr != exp_wr) n_order_err++;
                if (a_wr_addr >= wr_limit) n_hi_wr++;
                exp_wr = a_wr_addr + 32'd4;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int strips_of(input int n);
        return (n + 127) / 128;
    endfunction

    task automatic fill(input int n, input bit wrap_mode);
        for (int i = 0; i < n + 1; i++) begin
            if (wrap_mode) begin
                mem[B_BASE[13:2] + i] = 32'hFFFF_FFFF;
                mem[C_BASE[13:2] + i] = 32'(i + 2);
            end else begin
                mem[B_BASE[13:2] + i] = 32'(i) * 32'h0101_0101 + 32'h0000_0033;
                mem[C_BASE[13:2] + i] = ~(32'(i) * 32'd7);
            end
            mem[A_BASE[13:2] + i] = 32'h0;
        end
        mem[A_BASE[13:2] + n] = GUARD;
    endtask

    task automatic clear_mon(input logic [31:0] abase, input int n);
        n_brd = 0; n_crd = 0; n_wr = 0; n_done = 0;
        n_order_err = 0; n_hi_wr = 0;
        exp_wr = abase;
        wr_limit = abase + 32'(4 * n);
    endtask

    // Launch a run; optionally pokes start with other inputs mid-run.
    task automatic run(input int n, input bit poke, output int lat);
        @(negedge clk);
        clear_mon(A_BASE, n);
        n_elems = 32'(n); a_base = A_BASE; b_base = B_BASE; c_base = C_BASE;
        start = 1'b1;
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 5000) begin
            if (poke && lat == 20) begin
                start = 1'b1; n_elems = 32'd7; a_base = ALT_BASE;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!done, "R9", "done width", done, 0);
    endtask

    task automatic check_sums(input int n, input string req);
        int bad = 0;
        logic [31:0] e, a;
        logic [31:0] first_a = '0, first_e = '0;
        for (int i = 0; i < n; i++) begin
            e = mem[B_BASE[13:2] + i] + mem[C_BASE[13:2] + i];
            a = mem[A_BASE[13:2] + i];
            if (a !== e) begin
                if (bad == 0) begin first_a = a; first_e = e; end
                bad++;
            end
        end
        check(bad == 0, req, "sum value", first_a, first_e);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!done, "R1", "done after reset", done, 0);
        check(!b_rd_en && !c_rd_en, "R1", "read enables after reset", b_rd_en | c_rd_en, 0);
        check(!a_wr_en, "R1", "write enable after reset", a_wr_en, 0);
    endtask

    task automatic t_short;
        int lat;
        fill(5, 1'b0);
        run(5, 1'b0, lat);
        check(lat == 5 + 3, "R6", "short run latency", lat, 8);
        check_sums(5, "R2");
        check(n_wr == 5 && n_order_err == 0, "R7", "short write order errors", n_order_err, 0);
        check(n_done == 1, "R9", "done pulses", n_done, 1);
    endtask

    task automatic t_full_strip;
        int lat;
        fill(128, 1'b0);
        run(128, 1'b0, lat);
        check(lat == 128 + 3, "R6", "full strip latency", lat, 131);
        check(n_brd == 128 && n_crd == 128, "R3", "reads in one full strip", n_brd, 128);
        check_sums(128, "R2");
        check(mem[A_BASE[13:2] + 128] == GUARD, "R5", "guard after full strip",
              mem[A_BASE[13:2] + 128], GUARD);
    endtask

    task automatic t_multi;
        int lat;
        fill(300, 1'b0);
        run(300, 1'b0, lat);
        check(lat == 300 + 3 * strips_of(300), "R6", "three strip latency", lat, 309);
        check(n_brd == 300 && n_crd == 300, "R3", "total reads", n_brd, 300);
        check_sums(300, "R4");
        check(mem[A_BASE[13:2] + 300] == GUARD && n_hi_wr == 0, "R5", "writes beyond N",
              n_hi_wr, 0);
        check(n_order_err == 0 && n_wr == 300, "R7", "multi-strip write order", n_order_err, 0);
    endtask

    task automatic t_wrap;
        int lat;
        fill(9, 1'b1);
        run(9, 1'b0, lat);
        check(mem[A_BASE[13:2]] == 32'd1, "R2", "wrap sum element 0", mem[A_BASE[13:2]], 1);
        check_sums(9, "R2");
    endtask

    task automatic t_zero;
        int lat;
        run(0, 1'b0, lat);
        check(lat == 0, "R8", "zero-length latency", lat, 0);
        check(n_brd == 0 && n_crd == 0 && n_wr == 0, "R8", "zero-length accesses",
              n_brd + n_crd + n_wr, 0);
    endtask

    task automatic t_busy;
        int lat;
        fill(200, 1'b0);
        for (int i = 0; i < 8; i++) mem[ALT_BASE[13:2] + i] = GUARD;
        run(200, 1'b1, lat);
        check(lat == 200 + 3 * strips_of(200), "R10", "latency with mid-run start", lat, 206);
        check(n_done == 1, "R10", "done pulses with mid-run start", n_done, 1);
        check(mem[ALT_BASE[13:2]] == GUARD && n_hi_wr == 0, "R10", "alternate region",
              mem[ALT_BASE[13:2]], GUARD);
        check_sums(200, "R10");
        // The block must be idle again: no traffic in the following cycles.
        clear_mon(A_BASE, 0);
        repeat (10) @(negedge clk);
        check(n_brd == 0 && n_wr == 0, "R10", "quiet after run", n_brd + n_wr, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        clear_mon(A_BASE, 0);
        t_reset();
        t_short();
        t_full_strip();
        t_multi();
        t_wrap();
        t_zero();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule